// File: doc/BRIEF.md
# Interrupt Source Presented/Queued Tracker

This block keeps a two-bit state for each interrupt source in a small array. The low bit, P, records that the source has been handed to the downstream presentation controller. The high bit, Q, records that a further trigger arrived while the source was still presented. A source is either message-signalled or level-sensitive. Message-signalled sources coalesce a retrigger into Q, and an end-of-interrupt (EOI) replays it. Level-sensitive sources keep their asserted line in P, and an EOI re-presents them while the line is still high.

Trigger events carry a source index and a level. EOI events carry a source index, and one index number is reserved for inter-processor interrupts. The block raises a one-cycle present strobe with a source index. It does not arbitrate priority, route to servers or mask sources. For save and restore, any source's state can be read as a 64-bit word and overwritten with one.

Top module: `pq_tracker`

## Requirements
- R1: After reset every source reads back as a message-signalled source with P=0 and Q=0, so the save word is all zeros, and no present strobe is raised.
- R2: A level-1 trigger on a message-signalled source sets the state to {Q=old P, P=1}. A present strobe for that source follows only when the resulting state is P=1, Q=0.
- R3: A level-0 trigger on a message-signalled source changes no state and raises no strobe.
- R4: On a level-sensitive source, a level-1 trigger while P is set does nothing. A level-1 trigger with P clear sets the state to P=1, Q=0 and presents. A level-0 trigger clears both bits.
- R5: An EOI on a message-signalled source moves Q into P and clears Q. If the new P is 1 the source is presented again.
- R6: An EOI on a level-sensitive source leaves its state unchanged and presents the source again when P is set.
- R7: An EOI whose index equals the reserved inter-processor number (parameter, default 0) changes no source state and raises no strobe.
- R8: In the save word, bit 40 is level-sensitive, bit 41 is masked (always read as 0), bit 42 is pending (set for a level-sensitive source whenever P is set, otherwise 0), bit 43 is P and bit 44 is Q. All other bits read as 0.
- R9: A state write sets the level-sensitive flag from bit 40, sets P when bit 43 or bit 42 is 1, and sets Q from bit 44. All other bits are ignored.
- R10: A trigger and an EOI for the same source in one cycle act as one update: the EOI is applied first, then the trigger on its result. The present strobe is raised if either step asks for it.
- R11: The present strobe appears on the clock edge after the event, for one cycle. When a trigger and an EOI on different sources both ask to present in the same cycle, only the trigger's source index is sent.
- R12: A state write to a source in the same cycle as a trigger or EOI to that source discards those events: the written value is stored and no strobe is raised for that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Trigger event valid |
| trig_idx | input | IDX_W | Trigger source index |
| trig_level | input | 1 | Trigger level (1 assert, 0 deassert) |
| eoi_valid | input | 1 | EOI event valid |
| eoi_idx | input | IDX_W | EOI source index |
| st_wr_en | input | 1 | Write the save word into source st_idx |
| st_idx | input | IDX_W | Source selected for state read and write |
| st_wdata | input | 64 | Save word to restore |
| st_rdata | output | 64 | Save word of source st_idx (combinational) |
| pres_valid | output | 1 | Present strobe |
| pres_idx | output | IDX_W | Source index to present |

## Verification
The bench uses the default parameters: 16 sources with a 4-bit index and reserved EOI number 0. With these values the full index width is decoded, and the reserved number falls on a real source. That source can then be triggered and presented while its EOI must be ignored. Under these settings the bench drives same-cycle event pairs on one source and on two different sources, and restore words that mix the legacy pending bit with the queued bit.

// File: rtl/pq_pkg.sv
package pq_pkg;

    // Two-bit coalescing state: p is bit 0, q is bit 1.
    typedef struct packed {
        logic q;
        logic p;
    } pq_t;

    typedef struct packed {
        logic lsi;
        pq_t  pq;
    } src_state_t;

    localparam pq_t PQ_IDLE   = '{q: 1'b0, p: 1'b0};
    localparam pq_t PQ_P_ONLY = '{q: 1'b0, p: 1'b1};

    // Save word bit positions.
    localparam int SW_LSI  = 40;
    localparam int SW_MASK = 41;
    localparam int SW_PEND = 42;
    localparam int SW_PRES = 43;
    localparam int SW_QUE  = 44;

    // Message-signalled trigger: old P slides into Q, P set.
    function automatic pq_t msg_trigger(input pq_t s);
        pq_t r;
        r.q = s.p;
        r.p = 1'b1;
        return r;
    endfunction

    // Message-signalled EOI: Q slides into P, Q cleared.
    function automatic pq_t msg_eoi(input pq_t s);
        pq_t r;
        r.q = 1'b0;
        r.p = s.q;
        return r;
    endfunction

    function automatic logic [63:0] pack_save(input src_state_t s);
        logic [63:0] w;
        w          = '0;
        w[SW_LSI]  = s.lsi;
        w[SW_MASK] = 1'b0;
        w[SW_PEND] = s.lsi & s.pq.p;
        w[SW_PRES] = s.pq.p;
        w[SW_QUE]  = s.pq.q;
        return w;
    endfunction

    function automatic src_state_t unpack_save(input logic [63:0] w);
        src_state_t s;
        s.lsi  = w[SW_LSI];
        s.pq.p = w[SW_PRES] | w[SW_PEND];
        s.pq.q = w[SW_QUE];
        return s;
    endfunction

endpackage

// File: rtl/pq_src_cell.sv
module pq_src_cell
    import pq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_hit,
    input  logic       trig_level,
    input  logic       eoi_hit,
    input  logic       wr_hit,
    input  src_state_t wr_state,
    output src_state_t cur,
    output logic       trig_pres,
    output logic       eoi_pres
);

    src_state_t state_q;
    src_state_t state_d;
    pq_t        after_eoi;
    pq_t        after_trig;
    logic       trig_applied;

    assign cur = state_q;

    // Step 1: EOI on the current state.
    always_comb begin
        after_eoi = state_q.pq;
        if (eoi_hit) begin
            after_eoi = state_q.lsi ? state_q.pq : msg_eoi(state_q.pq);
        end
    end

    assign eoi_pres = eoi_hit & after_eoi.p;

    // Step 2: trigger on the post-EOI state.
    always_comb begin
        after_trig   = after_eoi;
        trig_applied = 1'b0;
        if (trig_hit) begin
            if (state_q.lsi) begin
                if (!trig_level) begin
                    after_trig   = PQ_IDLE;
                    trig_applied = 1'b1;
                end else if (!after_eoi.p) begin
                    after_trig   = PQ_P_ONLY;
                    trig_applied = 1'b1;
                end
            end else if (trig_level) begin
                after_trig   = msg_trigger(after_eoi);
                trig_applied = 1'b1;
            end
        end
    end

    assign trig_pres = trig_applied & (after_trig == PQ_P_ONLY);

    always_comb begin
        if (wr_hit) begin
            state_d = wr_state;
        end else begin
            state_d.lsi = state_q.lsi;
            state_d.pq  = after_trig;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R2: a level-1 trigger on a message source leaves P set.
    p_msg_trig_sets_p_r2: assert property (@(posedge clk) disable iff (rst)
        (trig_hit && trig_level && !state_q.lsi && !wr_hit) |=> state_q.pq.p);

    // R3: a level-0 trigger on a message source is a no-op.
    p_msg_lvl0_noop_r3: assert property (@(posedge clk) disable iff (rst)
        (trig_hit && !trig_level && !state_q.lsi && !eoi_hit && !wr_hit)
        |=> (state_q == $past(state_q)));

    // R4: a level-0 trigger on a level source clears it.
    p_lsi_lvl0_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (trig_hit && !trig_level && state_q.lsi && !wr_hit) |=> (state_q.pq == PQ_IDLE));

    // R6: an EOI alone leaves a level source unchanged.
    p_lsi_eoi_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (eoi_hit && state_q.lsi && !trig_hit && !wr_hit) |=> (state_q == $past(state_q)));

endmodule

// File: rtl/pq_present_arb.sv
module pq_present_arb #(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] trig_pres_vec,
    input  logic [NUM_SRC-1:0] eoi_pres_vec,
    input  logic [IDX_W-1:0]   trig_idx,
    input  logic [IDX_W-1:0]   eoi_idx,
    output logic               pres_valid,
    output logic [IDX_W-1:0]   pres_idx
);

    logic any_trig;
    logic any_eoi;

    assign any_trig = |trig_pres_vec;
    assign any_eoi  = |eoi_pres_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            pres_valid <= 1'b0;
            pres_idx   <= '0;
        end else begin
            pres_valid <= any_trig | any_eoi;
            if (any_trig) begin
                pres_idx <= trig_idx;
            end else if (any_eoi) begin
                pres_idx <= eoi_idx;
            end
        end
    end

    // R11: a trigger-caused present wins the single strobe.
    p_trig_priority_r11: assert property (@(posedge clk) disable iff (rst)
        any_trig |=> (pres_valid && pres_idx == $past(trig_idx)));

    // R5: an EOI replay alone is sent with the EOI index.
    p_eoi_replay_r5: assert property (@(posedge clk) disable iff (rst)
        (any_eoi && !any_trig) |=> (pres_valid && pres_idx == $past(eoi_idx)));

endmodule

// File: rtl/pq_save_view.sv
module pq_save_view
    import pq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  src_state_t [NUM_SRC-1:0] states,
    input  logic [IDX_W-1:0]         sel,
    output logic [63:0]              word
);

    always_comb begin
        word = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (sel == IDX_W'(k)) begin
                word = pack_save(states[k]);
            end
        end
    end

endmodule

// File: rtl/pq_tracker.sv
module pq_tracker
    import pq_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int IDX_W    = $clog2(NUM_SRC),
    parameter int RSVD_EOI = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_valid,
    input  logic [IDX_W-1:0] trig_idx,
    input  logic             trig_level,
    input  logic             eoi_valid,
    input  logic [IDX_W-1:0] eoi_idx,
    input  logic             st_wr_en,
    input  logic [IDX_W-1:0] st_idx,
    input  logic [63:0]      st_wdata,
    output logic [63:0]      st_rdata,
    output logic             pres_valid,
    output logic [IDX_W-1:0] pres_idx
);

    localparam logic [IDX_W-1:0] RSVD_IDX = IDX_W'(RSVD_EOI);

    src_state_t [NUM_SRC-1:0] states;
    logic [NUM_SRC-1:0]       trig_pres_vec;
    logic [NUM_SRC-1:0]       eoi_pres_vec;
    src_state_t               wr_state;
    logic                     eoi_ok;
    logic                     unused_wdata_bits;

    assign wr_state          = unpack_save(st_wdata);
    assign unused_wdata_bits = ^{st_wdata[63:45], st_wdata[SW_MASK], st_wdata[39:0]};
    assign eoi_ok            = eoi_valid && (eoi_idx != RSVD_IDX);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic wr_hit;
        logic t_hit;
        logic e_hit;

        assign wr_hit = st_wr_en && (st_idx == IDX_W'(i));
        assign t_hit  = trig_valid && (trig_idx == IDX_W'(i)) && !wr_hit;
        assign e_hit  = eoi_ok && (eoi_idx == IDX_W'(i)) && !wr_hit;

        pq_src_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .trig_hit   (t_hit),
            .trig_level (trig_level),
            .eoi_hit    (e_hit),
            .wr_hit     (wr_hit),
            .wr_state   (wr_state),
            .cur        (states[i]),
            .trig_pres  (trig_pres_vec[i]),
            .eoi_pres   (eoi_pres_vec[i])
        );
    end

    pq_present_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .clk           (clk),
        .rst           (rst),
        .trig_pres_vec (trig_pres_vec),
        .eoi_pres_vec  (eoi_pres_vec),
        .trig_idx      (trig_idx),
        .eoi_idx       (eoi_idx),
        .pres_valid    (pres_valid),
        .pres_idx      (pres_idx)
    );

    pq_save_view #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_view (
        .states (states),
        .sel    (st_idx),
        .word   (st_rdata)
    );

    // R7: a reserved-number EOI alone never causes a strobe.
    p_rsvd_eoi_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && eoi_idx == RSVD_IDX && !trig_valid) |=> !pres_valid);

    // R12: a state write swallows a lone trigger on the same source.
    p_write_blocks_trig_r12: assert property (@(posedge clk) disable iff (rst)
        (st_wr_en && trig_valid && trig_idx == st_idx && !eoi_valid) |=> !pres_valid);

    // R11: no strobe without an event on the previous edge.
    p_strobe_needs_event_r11: assert property (@(posedge clk) disable iff (rst)
        (!trig_valid && !eoi_valid) |=> !pres_valid);

endmodule

// File: tb/pq_tracker_test.sv
module pq_tracker_test;

    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic             trig_valid;
    logic [IDX_W-1:0] trig_idx;
    logic             trig_level;
    logic             eoi_valid;
    logic [IDX_W-1:0] eoi_idx;
    logic             st_wr_en;
    logic [IDX_W-1:0] st_idx;
    logic [63:0]      st_wdata;
    logic [63:0]      st_rdata;
    logic             pres_valid;
    logic [IDX_W-1:0] pres_idx;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [63:0] B_LSI  = 64'd1 << 40;
    localparam logic [63:0] B_MASK = 64'd1 << 41;
    localparam logic [63:0] B_PEND = 64'd1 << 42;
    localparam logic [63:0] B_P    = 64'd1 << 43;
    localparam logic [63:0] B_Q    = 64'd1 << 44;

    always #5 clk = ~clk;

    pq_tracker uut (
        .clk(clk), .rst(rst),
        .trig_valid(trig_valid), .trig_idx(trig_idx), .trig_level(trig_level),
        .eoi_valid(eoi_valid), .eoi_idx(eoi_idx),
        .st_wr_en(st_wr_en), .st_idx(st_idx), .st_wdata(st_wdata),
        .st_rdata(st_rdata), .pres_valid(pres_valid), .pres_idx(pres_idx)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle of events, sample just after the edge.
    task automatic step(input logic tv, input int ti, input logic tl,
                        input logic ev, input int ei,
                        input logic we, input int wi, input logic [63:0] wd);
        @(negedge clk);
        trig_valid = tv; trig_idx = IDX_W'(ti); trig_level = tl;
        eoi_valid  = ev; eoi_idx  = IDX_W'(ei);
        st_wr_en   = we; st_idx   = IDX_W'(wi); st_wdata = wd;
        @(posedge clk);
        #1;
    endtask

    task automatic trig(input int i, input logic lvl);
        step(1'b1, i, lvl, 1'b0, 0, 1'b0, 0, 64'd0);
    endtask

    task automatic eoi(input int i);
        step(1'b0, 0, 1'b0, 1'b1, i, 1'b0, 0, 64'd0);
    endtask

    task automatic wr(input int i, input logic [63:0] d);
        step(1'b0, 0, 1'b0, 1'b0, 0, 1'b1, i, d);
    endtask

    task automatic rd(input int i, output logic [63:0] d);
        @(negedge clk);
        trig_valid = 1'b0; eoi_valid = 1'b0; st_wr_en = 1'b0;
        st_idx = IDX_W'(i);
        #1;
        d = st_rdata;
    endtask

    task automatic chk_pres(input string tag, input logic v, input int i);
        chk({tag, " strobe"}, {63'd0, pres_valid}, {63'd0, v});
        if (v) chk({tag, " index"}, {60'd0, pres_idx}, 64'(i));
    endtask

    task automatic t_reset;
        logic [63:0] d;
        chk_pres("R1 reset", 1'b0, 0);
        for (int i = 0; i < 16; i++) begin
            rd(i, d);
            chk("R1 reset word", d, 64'd0);
        end
    endtask

    task automatic t_msg;
        logic [63:0] d;
        trig(3, 1'b1); chk_pres("R2 first trigger", 1'b1, 3);
        rd(3, d);      chk("R2 state P", d, B_P);
        trig(3, 1'b1); chk_pres("R2 retrigger queued", 1'b0, 0);
        rd(3, d);      chk("R2 state PQ", d, B_P | B_Q);
        trig(3, 1'b1); chk_pres("R2 third trigger", 1'b0, 0);
        rd(3, d);      chk("R2 state stays PQ", d, B_P | B_Q);
        eoi(3);        chk_pres("R5 replay", 1'b1, 3);
        rd(3, d);      chk("R5 state P", d, B_P);
        eoi(3);        chk_pres("R5 no replay", 1'b0, 0);
        rd(3, d);      chk("R5 state idle", d, 64'd0);
        rd(3, d);      chk_pres("R11 strobe one cycle", 1'b0, 0);
    endtask

    task automatic t_msg_lvl0;
        logic [63:0] d;
        trig(5, 1'b0); chk_pres("R3 level0 idle", 1'b0, 0);
        rd(5, d);      chk("R3 idle stays", d, 64'd0);
        trig(5, 1'b1); chk_pres("R3 setup", 1'b1, 5);
        trig(5, 1'b0); chk_pres("R3 level0 on P", 1'b0, 0);
        rd(5, d);      chk("R3 P kept", d, B_P);
    endtask

    task automatic t_lsi;
        logic [63:0] d;
        wr(7, B_LSI);  chk_pres("R9 lsi write", 1'b0, 0);
        rd(7, d);      chk("R8 lsi idle word", d, B_LSI);
        trig(7, 1'b1); chk_pres("R4 assert", 1'b1, 7);
        rd(7, d);      chk("R8 lsi pending word", d, B_LSI | B_PEND | B_P);
        trig(7, 1'b1); chk_pres("R4 reassert", 1'b0, 0);
        rd(7, d);      chk("R4 reassert state", d, B_LSI | B_PEND | B_P);
        eoi(7);        chk_pres("R6 replay", 1'b1, 7);
        rd(7, d);      chk("R6 unchanged", d, B_LSI | B_PEND | B_P);
        trig(7, 1'b0); chk_pres("R4 deassert", 1'b0, 0);
        rd(7, d);      chk("R4 cleared", d, B_LSI);
        eoi(7);        chk_pres("R6 no replay", 1'b0, 0);
    endtask

    task automatic t_restore;
        logic [63:0] d;
        wr(9, B_PEND); rd(9, d); chk("R9 pending sets P", d, B_P);
        wr(9, B_Q);    rd(9, d); chk("R9 queued only", d, B_Q);
        trig(9, 1'b1); chk_pres("R2 from Q only", 1'b1, 9);
        rd(9, d);      chk("R2 from Q state", d, B_P);
        wr(9, ~(B_LSI | B_PEND));
        rd(9, d);      chk("R8 R9 junk ignored", d, B_P | B_Q);
        chk("R8 masked bit zero", d & B_MASK, 64'd0);
    endtask

    task automatic t_rsvd;
        logic [63:0] d;
        trig(0, 1'b1); chk_pres("R7 setup", 1'b1, 0);
        eoi(0);        chk_pres("R7 reserved eoi", 1'b0, 0);
        rd(0, d);      chk("R7 state kept", d, B_P);
    endtask

    task automatic t_same;
        logic [63:0] d;
        trig(4, 1'b1); chk_pres("R10 setup", 1'b1, 4);
        step(1'b1, 4, 1'b1, 1'b1, 4, 1'b0, 0, 64'd0);
        chk_pres("R10 eoi then trigger", 1'b1, 4);
        rd(4, d);      chk("R10 state P", d, B_P);
        trig(4, 1'b1); chk_pres("R10 queue", 1'b0, 0);
        step(1'b1, 4, 1'b1, 1'b1, 4, 1'b0, 0, 64'd0);
        chk_pres("R10 replay and requeue", 1'b1, 4);
        rd(4, d);      chk("R10 state PQ", d, B_P | B_Q);
    endtask

    task automatic t_prio;
        logic [63:0] d;
        trig(10, 1'b1); trig(10, 1'b1);
        step(1'b1, 11, 1'b1, 1'b1, 10, 1'b0, 0, 64'd0);
        chk_pres("R11 trigger wins", 1'b1, 11);
        rd(10, d);     chk("R11 eoi still applied", d, B_P);
        rd(11, d);     chk("R11 trigger applied", d, B_P);
    endtask

    task automatic t_wr_conflict;
        logic [63:0] d;
        step(1'b1, 12, 1'b1, 1'b0, 0, 1'b1, 12, 64'd0);
        chk_pres("R12 write beats trigger", 1'b0, 0);
        rd(12, d);     chk("R12 written value", d, 64'd0);
        trig(12, 1'b1); chk_pres("R12 setup", 1'b1, 12);
        trig(12, 1'b1);
        step(1'b0, 0, 1'b0, 1'b1, 12, 1'b1, 12, B_P);
        chk_pres("R12 write beats eoi", 1'b0, 0);
        rd(12, d);     chk("R12 written P", d, B_P);
    endtask

    logic done = 1'b0;

    initial begin
        rst = 1'b1;
        trig_valid = 1'b0; trig_idx = '0; trig_level = 1'b0;
        eoi_valid = 1'b0; eoi_idx = '0;
        st_wr_en = 1'b0; st_idx = '0; st_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_msg();
        t_msg_lvl0();
        t_lsi();
        t_restore();
        t_rsvd();
        t_same();
        t_prio();
        t_wr_conflict();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule